// File: doc/BRIEF.md
# Sub-line instruction fetch window buffer

This block sits beside the fetch stage of a multithreaded core. Each hardware thread owns a copy of one instruction-cache line and a movable window inside it that is `BUF_BYTES` wide (at most one line). A fetch request carries a thread number and a byte address. The block answers in the same cycle. It reports a hit and up to `FETCH_W` aligned instruction words when the address falls inside that thread's window. Otherwise it raises a refill request toward the cache, naming the line and the reason. A fill returning from the cache loads the thread's line copy.

Each thread runs a three-state machine. The state encoding is Empty = 0, Pending = 1 and Ready = 2, and it appears on `thr_state`, two bits per thread, with thread i in bits [2i+1:2i]. The transitions are: Empty to Pending on a refill (cold miss); Pending to Ready on an accepted fill; Ready to Pending on a refill (cross-line, backward or overrun miss); and any state to Empty on flush. Requests to a Pending thread stall. A request never opens a second refill while one is outstanding. A buffer larger than a line stops elaboration. Addresses are assumed aligned to `INSTR_BYTES`. Line data is little-endian: byte b of the line is `fill_data[8b+7:8b]`, and instruction word w is `fill_data[32w+31:32w]` for 4-byte instructions.

Top module: `fetch_window_buf`

## Requirements
- R1: While reset is held, every thread reads Empty on `thr_state` and `hit` stays 0.
- R2: A valid request to an Empty thread raises `refill_req` in the same cycle with `refill_cause` = 0 (cold). `refill_line` is the address with its low log2(LINE_BYTES) bits cleared, and `refill_tid` is the request's thread. The thread reads Pending from the next cycle.
- R3: A valid request to a Pending thread raises `stall`, with `hit` = 0 and `refill_req` = 0.
- R4: A fill for a Pending thread moves it to Ready on the next cycle and stores the line. A fill for a thread that is not Pending changes nothing: its state holds and its later requests still miss.
- R5: A request hits when its thread is Ready, its line address matches the stored one, and its in-line offset o satisfies base <= o < base + BUF_BYTES. On a hit, slot 0 carries the instruction word at offset o.
- R6: Slot k (0 <= k < FETCH_W) is valid exactly when the request hits and o + k*INSTR_BYTES is both below base + BUF_BYTES and below LINE_BYTES. A valid slot carries the word at that offset.
- R7: A request to a Ready thread whose line address differs from the stored one raises `refill_req` with cause 1 (cross-line).
- R8: A same-line request to a Ready thread with offset below the window base raises `refill_req` with cause 2 (backward).
- R9: A same-line request to a Ready thread with offset at least base + BUF_BYTES raises `refill_req` with cause 3 (overrun).
- R10: Every refill sets the thread's window base to the requested offset. The base then holds through the fill until the next refill, flush or reset, and reset sets it to 0.
- R11: A request, refill or fill on one thread leaves every other thread's state, line and window unchanged.
- R12: A flush returns every thread to Empty with base 0. A fill arriving afterwards for a thread that had been Pending is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop every thread's line and window |
| req_valid | input | 1 | Fetch request present |
| req_tid | input | TID_W | Thread of the request |
| req_addr | input | ADDR_W | Byte address of the request |
| fill_valid | input | 1 | Cache fill present |
| fill_tid | input | TID_W | Thread the fill belongs to |
| fill_data | input | LINE_BYTES*8 | Full line of fill data |
| hit | output | 1 | Request served from the window |
| stall | output | 1 | Request waits on an outstanding refill |
| refill_req | output | 1 | Line refill needed |
| refill_tid | output | TID_W | Thread for the refill |
| refill_line | output | ADDR_W | Line-aligned refill address |
| refill_cause | output | 2 | 0 cold, 1 cross-line, 2 backward, 3 overrun |
| slot_valid | output | FETCH_W | Per-slot instruction valid |
| slot_data | output | FETCH_W*INSTR_BYTES*8 | Instruction words, slot k in bits [k*IW +: IW] |
| thr_state | output | THREADS*2 | Per-thread state code |

## Verification
The hardest situation to reach from the ports is a window whose nominal end lies past the end of the line. In that case slot validity is cut by the line boundary rather than by the window. Getting there needs a prior overrun miss near the end of a Ready line, so that the base lands in the last few words, and then a fill and a request just above that base. The stimulus reaches it with a directed chain of miss, fill and request. The random phase biases offsets toward each thread's recorded base, so that backward, in-window and overrun outcomes all recur around moving windows. It also fires occasional flushes while fills are still on their way.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;

    typedef enum logic [1:0] {
        TS_EMPTY = 2'd0,
        TS_PEND  = 2'd1,
        TS_READY = 2'd2
    } tstate_e;

    typedef enum logic [1:0] {
        MC_COLD  = 2'd0,
        MC_XLINE = 2'd1,
        MC_BACK  = 2'd2,
        MC_OVER  = 2'd3
    } mcause_e;

endpackage

// File: rtl/fbuf_thread.sv
module fbuf_thread
    import fbuf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    localparam int LOFF_W    = $clog2(LINE_BYTES),
    localparam int LBITS     = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              miss_take,
    input  logic [ADDR_W-1:0] miss_line,
    input  logic [LOFF_W-1:0] miss_off,
    input  logic              fill_take,
    input  logic [LBITS-1:0]  fill_data,
    output tstate_e           st,
    output logic [ADDR_W-1:0] line_addr,
    output logic [LOFF_W-1:0] base,
    output logic [LBITS-1:0]  line_data
);

    tstate_e st_q, st_d;
    logic [ADDR_W-1:0] line_q;
    logic [LOFF_W-1:0] base_q;
    logic [LBITS-1:0]  data_q;

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = TS_EMPTY;
        end else begin
            unique case (st_q)
                TS_EMPTY: if (miss_take) st_d = TS_PEND;
                TS_PEND:  if (fill_take) st_d = TS_READY;
                TS_READY: if (miss_take) st_d = TS_PEND;
                default:  st_d = TS_EMPTY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TS_EMPTY;
        else        st_q <= st_d;
    end

    // line address, window base and line copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            base_q <= '0;
            data_q <= '0;
        end else if (flush) begin
            base_q <= '0;
        end else begin
            if (miss_take && st_q != TS_PEND) begin
                line_q <= miss_line;
                base_q <= miss_off;
            end
            if (fill_take && st_q == TS_PEND) begin
                data_q <= fill_data;
            end
        end
    end

    assign st        = st_q;
    assign line_addr = line_q;
    assign base      = base_q;
    assign line_data = data_q;

    // R2: a refill outside a pending wait records the line and moves to Pending
    p_miss_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_take && !flush && st_q != TS_PEND)
        |=> (st_q == TS_PEND && line_q == $past(miss_line) && base_q == $past(miss_off)));

    // R4: an accepted fill makes the line Ready
    p_fill_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_take && !flush && st_q == TS_PEND) |=> (st_q == TS_READY));

    // R4: a fill for a thread that is not waiting leaves its state alone
    p_fill_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_take && !flush && !miss_take && st_q != TS_PEND) |=> $stable(st_q));

    // R12: flush empties the thread and zeroes its base
    p_flush_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q == TS_EMPTY && base_q == '0));

    // R10: a Ready thread keeps its window and line untouched until a refill or flush
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TS_READY && !miss_take && !flush)
        |=> ($stable(base_q) && $stable(line_q) && $stable(data_q)));

endmodule

// File: rtl/fbuf_window.sv
module fbuf_window
    import fbuf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int BUF_BYTES  = 64,
    localparam int LOFF_W    = $clog2(LINE_BYTES)
) (
    input  tstate_e           st,
    input  logic [ADDR_W-1:0] line_addr,
    input  logic [LOFF_W-1:0] base,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              in_win,
    output logic              pending,
    output mcause_e           cause,
    output logic [LOFF_W:0]   rel,
    output logic [LOFF_W-1:0] off,
    output logic [ADDR_W-1:0] req_line
);

    localparam logic [LOFF_W:0] BUF_L = (LOFF_W + 1)'(BUF_BYTES);

    logic same_line;
    logic below;
    logic past_end;

    always_comb begin
        off       = req_addr[LOFF_W-1:0];
        req_line  = {req_addr[ADDR_W-1:LOFF_W], {LOFF_W{1'b0}}};
        same_line = (req_line == line_addr);
        below     = (off < base);
        rel       = {1'b0, off} - {1'b0, base};
        past_end  = !below && (rel >= BUF_L);
        pending   = (st == TS_PEND);
        in_win    = (st == TS_READY) && same_line && !below && !past_end;

        if (st != TS_READY)  cause = MC_COLD;
        else if (!same_line) cause = MC_XLINE;
        else if (below)      cause = MC_BACK;
        else                 cause = MC_OVER;
    end

endmodule

// File: rtl/fbuf_slots.sv
module fbuf_slots #(
    parameter int LINE_BYTES  = 64,
    parameter int BUF_BYTES   = 64,
    parameter int INSTR_BYTES = 4,
    parameter int FETCH_W     = 4,
    localparam int LOFF_W     = $clog2(LINE_BYTES),
    localparam int LBITS      = LINE_BYTES * 8,
    localparam int IW         = INSTR_BYTES * 8
) (
    input  logic                  hit,
    input  logic [LBITS-1:0]      line_data,
    input  logic [LOFF_W-1:0]     off,
    input  logic [LOFF_W:0]       rel,
    output logic [FETCH_W-1:0]    slot_valid,
    output logic [FETCH_W*IW-1:0] slot_data
);

    localparam int WORDS  = LINE_BYTES / INSTR_BYTES;
    localparam int WIDX_W = $clog2(WORDS);
    localparam int IB_W   = $clog2(INSTR_BYTES);
    localparam int SW     = LOFF_W + $clog2(FETCH_W * INSTR_BYTES) + 2;

    for (genvar k = 0; k < FETCH_W; k++) begin : g_slot
        localparam int STEP = k * INSTR_BYTES;
        logic [SW-1:0]     o_k;
        logic [SW-1:0]     r_k;
        logic [WIDX_W-1:0] widx;

        assign o_k  = SW'(off) + SW'(STEP);
        assign r_k  = SW'(rel) + SW'(STEP);
        assign widx = off[LOFF_W-1:IB_W] + WIDX_W'(k);

        assign slot_valid[k]        = hit && (r_k < SW'(BUF_BYTES)) && (o_k < SW'(LINE_BYTES));
        assign slot_data[k*IW +: IW] = line_data[widx*IW +: IW];
    end

endmodule

// File: rtl/fetch_window_buf.sv
module fetch_window_buf
    import fbuf_pkg::*;
#(
    parameter int THREADS     = 2,
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 64,
    parameter int BUF_BYTES   = 64,
    parameter int INSTR_BYTES = 4,
    parameter int FETCH_W     = 4,
    localparam int TID_W      = (THREADS > 1) ? $clog2(THREADS) : 1,
    localparam int LBITS      = LINE_BYTES * 8,
    localparam int IW         = INSTR_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic                  req_valid,
    input  logic [TID_W-1:0]      req_tid,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  fill_valid,
    input  logic [TID_W-1:0]      fill_tid,
    input  logic [LBITS-1:0]      fill_data,
    output logic                  hit,
    output logic                  stall,
    output logic                  refill_req,
    output logic [TID_W-1:0]      refill_tid,
    output logic [ADDR_W-1:0]     refill_line,
    output logic [1:0]            refill_cause,
    output logic [FETCH_W-1:0]    slot_valid,
    output logic [FETCH_W*IW-1:0] slot_data,
    output logic [THREADS*2-1:0]  thr_state
);

    localparam int LOFF_W = $clog2(LINE_BYTES);

    if (BUF_BYTES > LINE_BYTES) begin : g_bad_cfg
        $error("fetch_window_buf: BUF_BYTES must not exceed LINE_BYTES");
    end

    tstate_e           st_a   [THREADS];
    logic [ADDR_W-1:0] line_a [THREADS];
    logic [LOFF_W-1:0] base_a [THREADS];
    logic [LBITS-1:0]  data_a [THREADS];
    logic [THREADS-1:0] miss_take_v;
    logic [THREADS-1:0] fill_take_v;

    for (genvar i = 0; i < THREADS; i++) begin : g_thr
        assign miss_take_v[i] = refill_req && (req_tid == TID_W'(i));
        assign fill_take_v[i] = fill_valid && (fill_tid == TID_W'(i));
        assign thr_state[2*i +: 2] = st_a[i];

        fbuf_thread #(
            .ADDR_W    (ADDR_W),
            .LINE_BYTES(LINE_BYTES)
        ) u_thr (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .miss_take(miss_take_v[i]),
            .miss_line(refill_line),
            .miss_off (req_addr[LOFF_W-1:0]),
            .fill_take(fill_take_v[i]),
            .fill_data(fill_data),
            .st       (st_a[i]),
            .line_addr(line_a[i]),
            .base     (base_a[i]),
            .line_data(data_a[i])
        );
    end

    logic              in_win;
    logic              pend;
    mcause_e           cause;
    logic [LOFF_W:0]   rel;
    logic [LOFF_W-1:0] off;
    logic [ADDR_W-1:0] req_line;

    fbuf_window #(
        .ADDR_W    (ADDR_W),
        .LINE_BYTES(LINE_BYTES),
        .BUF_BYTES (BUF_BYTES)
    ) u_win (
        .st       (st_a[req_tid]),
        .line_addr(line_a[req_tid]),
        .base     (base_a[req_tid]),
        .req_addr (req_addr),
        .in_win   (in_win),
        .pending  (pend),
        .cause    (cause),
        .rel      (rel),
        .off      (off),
        .req_line (req_line)
    );

    // request outcome
    always_comb begin
        hit          = req_valid && in_win;
        stall        = req_valid && pend;
        refill_req   = req_valid && !in_win && !pend;
        refill_tid   = req_tid;
        refill_line  = req_line;
        refill_cause = cause;
    end

    fbuf_slots #(
        .LINE_BYTES (LINE_BYTES),
        .BUF_BYTES  (BUF_BYTES),
        .INSTR_BYTES(INSTR_BYTES),
        .FETCH_W    (FETCH_W)
    ) u_slots (
        .hit       (hit),
        .line_data (data_a[req_tid]),
        .off       (off),
        .rel       (rel),
        .slot_valid(slot_valid),
        .slot_data (slot_data)
    );

    // R3: a stalled request neither hits nor refills
    p_stall_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!hit && !refill_req));

    // R5: any hit delivers at least the first slot
    p_hit_slot0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> slot_valid[0]);

    // R6: valid slots form an unbroken run from slot 0
    p_slot_thermo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_valid & (slot_valid + FETCH_W'(1))) == '0));

    // R2: the thread named by a refill is Pending on the next cycle
    p_refill_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && !flush) |=> (st_a[$past(req_tid)] == TS_PEND));

endmodule

// File: tb/fetch_window_buf_test.sv
`timescale 1ns/1ps
module fetch_window_buf_test;

    localparam int TH = 2;
    localparam int LN = 64;
    localparam int BF = 16;
    localparam int FW = 3;
    localparam int IB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic req_valid = 1'b0;
    logic [0:0] req_tid = '0;
    logic [31:0] req_addr = '0;
    logic fill_valid = 1'b0;
    logic [0:0] fill_tid = '0;
    logic [LN*8-1:0] fill_data = '0;
    logic hit, stall, refill_req;
    logic [0:0] refill_tid;
    logic [31:0] refill_line;
    logic [1:0] refill_cause;
    logic [FW-1:0] slot_valid;
    logic [FW*32-1:0] slot_data;
    logic [TH*2-1:0] thr_state;

    always #2.5 clk = ~clk;

    fetch_window_buf #(
        .THREADS(TH), .ADDR_W(32), .LINE_BYTES(LN), .BUF_BYTES(BF),
        .INSTR_BYTES(IB), .FETCH_W(FW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_tid(req_tid), .req_addr(req_addr),
        .fill_valid(fill_valid), .fill_tid(fill_tid), .fill_data(fill_data),
        .hit(hit), .stall(stall), .refill_req(refill_req), .refill_tid(refill_tid),
        .refill_line(refill_line), .refill_cause(refill_cause),
        .slot_valid(slot_valid), .slot_data(slot_data), .thr_state(thr_state)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    int m_st [TH];
    logic [31:0] m_line [TH];
    int m_base [TH];
    logic [LN*8-1:0] m_data [TH];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [LN*8-1:0] rnd_line();
        logic [LN*8-1:0] r;
        for (int i = 0; i < LN / 4; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    // one cycle: drive at negedge, check 1 ns later, update model for the next edge
    task automatic step(input bit rq, input int tid, input logic [31:0] addr,
                        input bit fv, input int ftid, input bit fl, input string tag);
        logic [LN*8-1:0] fd;
        logic [31:0] lb;
        int off, st, base, ecause;
        bit e_hit, e_stall, e_ref, fill_ok;
        string tg;
        fd = rnd_line();
        req_valid = rq; req_tid = 1'(tid); req_addr = addr;
        fill_valid = fv; fill_tid = 1'(ftid); fill_data = fd; flush = fl;
        #1;
        st = m_st[tid];
        base = m_base[tid];
        off = int'(addr % LN);
        lb = addr & ~32'(LN - 1);
        e_stall = rq && st == 1;
        e_hit = rq && st == 2 && lb == m_line[tid] && off >= base && (off - base) < BF;
        e_ref = rq && !e_hit && st != 1;
        if (st != 2) ecause = 0;
        else if (lb != m_line[tid]) ecause = 1;
        else if (off < base) ecause = 2;
        else ecause = 3;

        for (int i = 0; i < TH; i++) begin
            tg = (tag != "") ? tag : "R4";
            chk(thr_state[2*i +: 2] == 2'(m_st[i]), tg, "thr_state",
                64'(thr_state[2*i +: 2]), 64'(m_st[i]));
        end
        tg = (tag != "") ? tag : "R5";
        chk(hit == e_hit, tg, "hit", 64'(hit), 64'(e_hit));
        tg = (tag != "") ? tag : "R3";
        chk(stall == e_stall, tg, "stall", 64'(stall), 64'(e_stall));
        if (tag != "") tg = tag;
        else if (ecause == 0) tg = "R2";
        else if (ecause == 1) tg = "R7";
        else if (ecause == 2) tg = "R8";
        else tg = "R9";
        chk(refill_req == e_ref, tg, "refill_req", 64'(refill_req), 64'(e_ref));
        if (e_ref) begin
            chk(refill_cause == 2'(ecause), tg, "refill_cause", 64'(refill_cause), 64'(ecause));
            chk(refill_line == lb, tg, "refill_line", 64'(refill_line), 64'(lb));
            chk(refill_tid == 1'(tid), tg, "refill_tid", 64'(refill_tid), 64'(tid));
        end
        tg = (tag != "") ? tag : "R6";
        for (int k = 0; k < FW; k++) begin
            int o;
            bit ev;
            o = off + k * IB;
            ev = e_hit && (o - base) < BF && o < LN;
            chk(slot_valid[k] == ev, tg, "slot_valid", 64'(slot_valid[k]), 64'(ev));
            if (ev)
                chk(slot_data[k*32 +: 32] == m_data[tid][o*8 +: 32], tg, "slot_data",
                    64'(slot_data[k*32 +: 32]), 64'(m_data[tid][o*8 +: 32]));
        end

        fill_ok = fv && m_st[ftid] == 1;
        if (fl) begin
            for (int i = 0; i < TH; i++) begin m_st[i] = 0; m_base[i] = 0; end
        end else begin
            if (e_ref) begin m_st[tid] = 1; m_line[tid] = lb; m_base[tid] = off; end
            if (fill_ok) begin m_st[ftid] = 2; m_data[ftid] = fd; end
        end
        @(negedge clk);
        req_valid = 1'b0; fill_valid = 1'b0; flush = 1'b0;
    endtask

    initial begin
        #(5.0 * 30000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7771));
        for (int i = 0; i < TH; i++) begin
            m_st[i] = 0; m_line[i] = '0; m_base[i] = 0; m_data[i] = '0;
        end
        req_valid = 1'b1; req_addr = 32'h1000;
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk(thr_state == '0, "R1", "thr_state in reset", 64'(thr_state), 64'd0);
        chk(hit == 1'b0, "R1", "hit in reset", 64'(hit), 64'd0);
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // directed corner cases
        step(1, 0, 32'h1020, 0, 0, 0, "R2");   // cold miss, base 32
        step(1, 0, 32'h1020, 0, 0, 0, "R3");   // pending stall
        step(0, 0, 32'h0,    1, 1, 0, "R4");   // fill to Empty thread 1 ignored
        step(1, 1, 32'h2000, 0, 0, 0, "R4");   // thread 1 still cold-misses
        step(0, 0, 32'h0,    1, 0, 0, "R4");   // fill thread 0
        step(1, 0, 32'h1020, 0, 0, 0, "R10");  // hit at recorded base
        step(1, 0, 32'h1028, 0, 0, 0, "R6");   // two slots left in window
        step(1, 0, 32'h102C, 0, 0, 0, "R6");   // one slot left
        step(1, 0, 32'h1030, 0, 0, 0, "R9");   // overrun, base 48
        step(0, 0, 32'h0,    1, 0, 0, "R10");
        step(1, 0, 32'h1030, 0, 0, 0, "R10");  // hit at new base
        step(1, 0, 32'h102C, 0, 0, 0, "R8");   // backward, base 44
        step(0, 0, 32'h0,    1, 0, 0, "R8");
        step(1, 0, 32'h102C, 0, 0, 0, "R5");
        step(1, 0, 32'h1080, 0, 0, 0, "R7");   // cross-line, base 0
        step(0, 0, 32'h0,    1, 0, 0, "R7");
        step(1, 0, 32'h10B8, 0, 0, 0, "R9");   // overrun near line end, base 56
        step(0, 0, 32'h0,    1, 0, 0, "R9");
        step(1, 0, 32'h10BC, 0, 0, 0, "R6");   // slot 1 cut by line end
        step(0, 0, 32'h0,    1, 1, 0, "R11");  // thread 1 becomes Ready
        step(1, 0, 32'h10B8, 0, 0, 0, "R11");  // thread 0 window unaffected
        step(1, 1, 32'h3000, 0, 0, 0, "R11");  // thread 1 cross-line
        step(1, 0, 32'h10BC, 0, 0, 1, "R12");  // flush while thread 1 pending
        step(0, 0, 32'h0,    1, 1, 0, "R12");  // stale fill ignored
        step(1, 1, 32'h3000, 0, 0, 0, "R12");  // still a cold miss
        step(1, 0, 32'h10B8, 0, 0, 0, "R12");

        // constrained random phase
        for (int n = 0; n < 4000; n++) begin
            bit rq, fv, fl;
            int tid, ftid, off, sel;
            logic [31:0] lbase;
            rq = ($urandom % 4) != 0;
            tid = int'($urandom % TH);
            sel = int'($urandom % 3);
            lbase = (sel == 0) ? 32'h1000 : (sel == 1) ? 32'h1040 : 32'h8000;
            if (($urandom % 2) == 1 && m_st[tid] == 2) begin
                lbase = m_line[tid];
                off = (m_base[tid] + 4 * int'($urandom % 8) - 8) & (LN - 1);
            end else begin
                off = 4 * int'($urandom % (LN / 4));
            end
            ftid = int'($urandom % TH);
            fv = (m_st[ftid] == 1) ? (($urandom % 3) == 0) : (($urandom % 20) == 0);
            fl = ($urandom % 250) == 0;
            step(rq, tid, lbase + 32'(off), fv, ftid, fl, "");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule